// File: doc/BRIEF.md
# CD Decoder Host / Controller Mailbox Registers

This block sits between a host processor and the small controller CPU (here called the sub-CPU) that runs a CD decoder. The host issues a command byte and parameter bytes and reads back result bytes. The sub-CPU takes the parameters, writes results, raises up to three host interrupt lines, and clears both its own interrupt status and the handshake flags. Each side has a simple register port made of an address, write data, a write strobe, a read strobe and registered read data. A read returns its data one clock after the strobe edge. A write takes effect at the strobe edge, except for the two self-clearing clear registers, which act one clock later.

Results pass through a result FIFO of parameterised depth (8 bytes by default). A busy flag marks a command that the sub-CPU has not yet acknowledged. An 8-bit sticky interrupt status register collects events from the decoder core, from the buffer transfer engine and from the host side. A mask register selects which status bits drive the sub-CPU interrupt line.

Top module: `cdhif_regs`

Host map:
- 0: write command, read status.
- 1: write parameter.
- 2: read result.
- 3: write host clear. Bits 2:0 clear the host interrupts; bit 7 reports a host chip reset.

Sub-CPU map:
- 0: status.
- 1: read interrupt status, write one to clear.
- 2: read parameter, write result.
- 3: clear control. Bit 0 clears the results; bit 1 clears busy.
- 4: host interrupt raise.
- 5: mask.
- 6: last command.

## Requirements
- R1: After reset the status byte is 0x60 and the interrupt status, the sub-CPU interrupt and the host interrupt are all zero. In the status byte, bit 7 is busy, bit 6 is result-write-ready, bit 5 is result-empty, bit 4 is parameter-ready, bit 3 is DMA busy and bits 2:0 are the host interrupt flags.
- R2: Bytes written by the sub-CPU to address 2 are returned, in the same order, by host reads of address 2.
- R3: The result FIFO holds 8 bytes. Status bit 6 is low while it is full, and a write to a full FIFO is dropped.
- R4: A host read of an empty FIFO returns the most recently popped byte again and leaves the FIFO empty.
- R5: Status bit 5 is high exactly when the FIFO is empty. A host read that empties the FIFO sets interrupt status bit 5.
- R6: A host command write sets busy (status bit 7) and interrupt status bit 1, and sub address 6 returns the command byte. Busy is cleared only by a one in clear-control bit 1.
- R7: A host parameter write sets status bit 4. A sub-CPU read of address 2 returns the byte and clears bit 4.
- R8: The clear-control register reads back zero once its clear has been applied. Its bit 0 empties the result FIFO.
- R9: Interrupt status bits are sticky. Event input bit n sets bit n, a host clear write with bit 7 set sets bit 0, and writing a one at sub address 1 clears only that bit.
- R10: The sub-CPU interrupt is high when any interrupt status bit is set together with its mask bit. The mask never changes the interrupt status value.
- R11: Writing a one to bit n of sub address 4 sets host flag n, and writing a zero leaves it unchanged. A host clear write with a one in bit n clears flag n. The host interrupt output is the OR of the three flags.
- R12: When a set and a clear of the same flag fall in the same cycle, the set wins. This applies to an interrupt status bit and to busy.
- R13: Status bit 3 follows the DMA busy input with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_addr | input | ADDR_W | Host register address |
| h_wdata | input | DATA_W | Host write data |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_rdata | output | DATA_W | Host read data, valid the cycle after the strobe |
| s_addr | input | ADDR_W | Sub-CPU register address |
| s_wdata | input | DATA_W | Sub-CPU write data |
| s_wr | input | 1 | Sub-CPU write strobe |
| s_rd | input | 1 | Sub-CPU read strobe |
| s_rdata | output | DATA_W | Sub-CPU read data, valid the cycle after the strobe |
| evt_i | input | DATA_W | Event pulses that set interrupt status bits |
| dma_busy_i | input | 1 | Buffer transfer engine busy level |
| sub_irq_o | output | 1 | Masked interrupt to the sub-CPU |
| host_irq_o | output | 1 | OR of the host interrupt flags |

## Verification
A clear can land in the same cycle as a set of the same flag. This happens because the clear registers act one cycle after their write. The bench times an event pulse, or a host command write, to coincide with that pending clear cycle for an interrupt status bit and for busy. It then judges the outcome by reading the flag back and expecting it still set. A normal clear follows, showing that the flag drops once no set competes.

// File: rtl/cdhif_pkg.sv
package cdhif_pkg;
   // host side addresses
   localparam int HA_CMD  = 0;
   localparam int HA_PRM  = 1;
   localparam int HA_RES  = 2;
   localparam int HA_HCLR = 3;
   // sub-CPU side addresses
   localparam int SA_STAT = 0;
   localparam int SA_INT  = 1;
   localparam int SA_PRM  = 2;
   localparam int SA_CLR  = 3;
   localparam int SA_HINT = 4;
   localparam int SA_MASK = 5;
   localparam int SA_CMD  = 6;
   // status byte layout
   localparam int ST_BUSY = 7;
   localparam int ST_RWR  = 6;
   localparam int ST_REMP = 5;
   localparam int ST_PRDY = 4;
   localparam int ST_DMA  = 3;
   // interrupt status positions driven internally
   localparam int IS_HRST = 0;
   localparam int IS_HCMD = 1;
   localparam int IS_REMP = 5;
   // clear-control bits
   localparam int CLR_RES  = 0;
   localparam int CLR_BUSY = 1;
   // host clear: chip reset report bit
   localparam int HC_RST   = 7;
endpackage

// File: rtl/cdhif_pulse_reg.sv
module cdhif_pulse_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   // holds a written value for one cycle, then returns to zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
      else           q <= '0;
   end
endmodule

// File: rtl/cdhif_flagbank.sv
module cdhif_flagbank #(
   parameter int N        = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (SET_WINS) begin : g_setwin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
         end
      end else begin : g_clrwin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (clr[i]) q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cdhif_fifo.sv
module cdhif_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               head,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] cnt
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             push_ok, pop_ok;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/cdhif_regs.sv
module cdhif_regs
   import cdhif_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int RES_DEPTH = 8,
   parameter int N_HINT    = 3,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic              h_wr,
   input  logic              h_rd,
   output logic [DATA_W-1:0] h_rdata,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic              s_wr,
   input  logic              s_rd,
   output logic [DATA_W-1:0] s_rdata,
   input  logic [DATA_W-1:0] evt_i,
   input  logic              dma_busy_i,
   output logic              sub_irq_o,
   output logic              host_irq_o
);
   localparam int CNT_W = $clog2(RES_DEPTH+1);

   // elaboration-time parameter checks
   if (DATA_W != 8) begin : g_bad_dw
      $error("cdhif_regs: status layout needs DATA_W of 8");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("cdhif_regs: ADDR_W must cover seven sub-CPU registers");
   end
   if (RES_DEPTH < 2 || (RES_DEPTH & (RES_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cdhif_regs: RES_DEPTH must be a power of two, at least 2");
   end
   if (N_HINT < 1 || N_HINT > 3) begin : g_bad_hint
      $error("cdhif_regs: N_HINT must be 1 to 3");
   end

   // address decode
   logic h_cmd_wr, h_prm_wr, h_res_rd, h_clr_wr;
   logic s_int_wr, s_prm_rd, s_res_wr, s_clr_wr, s_hint_wr, s_mask_wr;

   assign h_cmd_wr  = h_wr && (int'(h_addr) == HA_CMD);
   assign h_prm_wr  = h_wr && (int'(h_addr) == HA_PRM);
   assign h_res_rd  = h_rd && (int'(h_addr) == HA_RES);
   assign h_clr_wr  = h_wr && (int'(h_addr) == HA_HCLR);
   assign s_int_wr  = s_wr && (int'(s_addr) == SA_INT);
   assign s_prm_rd  = s_rd && (int'(s_addr) == SA_PRM);
   assign s_res_wr  = s_wr && (int'(s_addr) == SA_PRM);
   assign s_clr_wr  = s_wr && (int'(s_addr) == SA_CLR);
   assign s_hint_wr = s_wr && (int'(s_addr) == SA_HINT);
   assign s_mask_wr = s_wr && (int'(s_addr) == SA_MASK);

   // self-clearing clear registers
   logic [DATA_W-1:0] clrc_q, iclr_q;

   cdhif_pulse_reg #(.W(DATA_W)) u_clrc (
      .clk(clk), .rst_n(rst_n), .load(s_clr_wr), .din(s_wdata), .q(clrc_q));

   cdhif_pulse_reg #(.W(DATA_W)) u_iclr (
      .clk(clk), .rst_n(rst_n), .load(s_int_wr), .din(s_wdata), .q(iclr_q));

   // result FIFO
   logic [DATA_W-1:0] fifo_head;
   logic              fifo_empty, fifo_full;
   logic [CNT_W-1:0]  fifo_cnt;

   cdhif_fifo #(.W(DATA_W), .DEPTH(RES_DEPTH)) u_res (
      .clk(clk), .rst_n(rst_n), .clr(clrc_q[CLR_RES]),
      .push(s_res_wr), .din(s_wdata), .pop(h_res_rd),
      .head(fifo_head), .empty(fifo_empty), .full(fifo_full), .cnt(fifo_cnt));

   // busy and parameter-ready flags
   logic busy_q, prm_rdy;

   cdhif_flagbank #(.N(1), .SET_WINS(SET_WINS)) u_busy (
      .clk(clk), .rst_n(rst_n), .set(h_cmd_wr), .clr(clrc_q[CLR_BUSY]), .q(busy_q));

   cdhif_flagbank #(.N(1), .SET_WINS(SET_WINS)) u_prdy (
      .clk(clk), .rst_n(rst_n), .set(h_prm_wr), .clr(s_prm_rd), .q(prm_rdy));

   // interrupt status
   logic [DATA_W-1:0] int_src, ists_q;
   logic              empties;

   assign empties = h_res_rd && (fifo_cnt == CNT_W'(1)) && !(s_res_wr && !fifo_full)
                    && !clrc_q[CLR_RES];

   always_comb begin
      int_src          = '0;
      int_src[IS_HRST] = h_clr_wr && h_wdata[HC_RST];
      int_src[IS_HCMD] = h_cmd_wr;
      int_src[IS_REMP] = empties;
   end

   cdhif_flagbank #(.N(DATA_W), .SET_WINS(SET_WINS)) u_ists (
      .clk(clk), .rst_n(rst_n), .set(evt_i | int_src), .clr(iclr_q), .q(ists_q));

   // host interrupt flags
   logic [N_HINT-1:0] hint_q, hint_set, hint_clr;

   assign hint_set = s_hint_wr ? s_wdata[N_HINT-1:0] : '0;
   assign hint_clr = h_clr_wr  ? h_wdata[N_HINT-1:0] : '0;

   cdhif_flagbank #(.N(N_HINT), .SET_WINS(SET_WINS)) u_hint (
      .clk(clk), .rst_n(rst_n), .set(hint_set), .clr(hint_clr), .q(hint_q));

   // plain registers
   logic [DATA_W-1:0] mask_q, cmd_q, prm_q, last_q;
   logic              dma_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         cmd_q  <= '0;
         prm_q  <= '0;
         last_q <= '0;
         dma_q  <= 1'b0;
      end else begin
         dma_q <= dma_busy_i;
         if (s_mask_wr) mask_q <= s_wdata;
         if (h_cmd_wr)  cmd_q  <= h_wdata;
         if (h_prm_wr)  prm_q  <= h_wdata;
         if (h_res_rd && !fifo_empty) last_q <= fifo_head;
      end
   end

   // status byte shared by both sides
   logic [DATA_W-1:0] stat_byte;
   logic [2:0]        hint3;

   assign hint3     = 3'(hint_q);
   assign stat_byte = {busy_q, !fifo_full, fifo_empty, prm_rdy, dma_q, hint3};

   // registered read data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_rdata <= '0;
      end else if (h_rd) begin
         case (int'(h_addr))
            HA_CMD:  h_rdata <= stat_byte;
            HA_RES:  h_rdata <= fifo_empty ? last_q : fifo_head;
            default: h_rdata <= '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_rdata <= '0;
      end else if (s_rd) begin
         case (int'(s_addr))
            SA_STAT: s_rdata <= stat_byte;
            SA_INT:  s_rdata <= ists_q;
            SA_PRM:  s_rdata <= prm_q;
            SA_CLR:  s_rdata <= clrc_q;
            SA_HINT: s_rdata <= DATA_W'(hint_q);
            SA_MASK: s_rdata <= mask_q;
            SA_CMD:  s_rdata <= cmd_q;
            default: s_rdata <= '0;
         endcase
      end
   end

   assign sub_irq_o  = |(ists_q & mask_q);
   assign host_irq_o = |hint_q;

   logic unused_hbits;
   assign unused_hbits = ^h_wdata[HC_RST-1:N_HINT];
endmodule

// File: rtl/cdhif_regs_chk.sv
module cdhif_regs_chk
   import cdhif_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int RES_DEPTH = 8,
   parameter int CNT_W     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] h_addr,
   input logic              h_wr,
   input logic [ADDR_W-1:0] s_addr,
   input logic              s_wr,
   input logic              s_rd,
   input logic              busy,
   input logic [7:0]        clrc,
   input logic [7:0]        ists,
   input logic [7:0]        iclr,
   input logic [CNT_W-1:0]  fifo_cnt,
   input logic              prm_rdy,
   input logic              host_irq
);
   AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && int'(h_addr) == HA_CMD) |=> busy); // R6

   AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !clrc[CLR_BUSY]) |=> busy); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fifo_cnt) <= RES_DEPTH); // R3

   AST_CLR_SELFRESET: assert property (@(posedge clk) disable iff (!rst_n)
      (clrc != 8'h00 && !(s_wr && int'(s_addr) == SA_CLR)) |=> (clrc == 8'h00)); // R8

   AST_ISTS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (iclr == 8'h00) |=> ((ists & $past(ists)) == $past(ists))); // R9

   AST_PRM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rd && int'(s_addr) == SA_PRM && !(h_wr && int'(h_addr) == HA_PRM)) |=> !prm_rdy); // R7

   AST_HINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_irq && !(h_wr && int'(h_addr) == HA_HCLR)) |=> host_irq); // R11
endmodule

bind cdhif_regs cdhif_regs_chk #(
   .ADDR_W(ADDR_W), .RES_DEPTH(RES_DEPTH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr),
   .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd), .busy(busy_q),
   .clrc(clrc_q), .ists(ists_q), .iclr(iclr_q), .fifo_cnt(fifo_cnt),
   .prm_rdy(prm_rdy), .host_irq(host_irq_o)
);

// File: tb/tb_cdhif_regs.sv
module tb_cdhif_regs;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] h_addr = '0, s_addr = '0;
   logic [7:0] h_wdata = '0, s_wdata = '0, evt_i = '0;
   logic       h_wr = 1'b0, h_rd = 1'b0, s_wr = 1'b0, s_rd = 1'b0, dma_busy_i = 1'b0;
   logic [7:0] h_rdata, s_rdata;
   logic       sub_irq_o, host_irq_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   cdhif_regs dut (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wdata(h_wdata), .h_wr(h_wr),
      .h_rd(h_rd), .h_rdata(h_rdata), .s_addr(s_addr), .s_wdata(s_wdata),
      .s_wr(s_wr), .s_rd(s_rd), .s_rdata(s_rdata), .evt_i(evt_i),
      .dma_busy_i(dma_busy_i), .sub_irq_o(sub_irq_o), .host_irq_o(host_irq_o));

   int n_chk = 0, n_bad = 0;
   string cur_tag = "R2";
   logic [7:0] model_q[$];
   logic [7:0] exp_q[$];
   logic [7:0] last_pop = 8'h00;
   logic pop_seen = 1'b0;
   logic done = 1'b0;

   task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic s_write(int a, logic [7:0] d);
      s_addr = 3'(a); s_wdata = d; s_wr = 1'b1;
      @(negedge clk);
      s_wr = 1'b0;
   endtask

   task automatic s_read(int a, output logic [7:0] d);
      s_addr = 3'(a); s_rd = 1'b1;
      @(negedge clk);
      s_rd = 1'b0;
      d = s_rdata;
   endtask

   task automatic h_write(int a, logic [7:0] d);
      h_addr = 3'(a); h_wdata = d; h_wr = 1'b1;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic h_read(int a, output logic [7:0] d);
      h_addr = 3'(a); h_rd = 1'b1;
      @(negedge clk);
      h_rd = 1'b0;
      d = h_rdata;
   endtask

   // driver side of the scoreboard
   task automatic drv_push(logic [7:0] d);
      s_write(2, d);
      if (model_q.size() < 8) model_q.push_back(d);
   endtask

   task automatic h_pop();
      logic [7:0] e;
      if (model_q.size() > 0) begin
         e = model_q.pop_front();
         last_pop = e;
      end else begin
         e = last_pop;
      end
      exp_q.push_back(e);
      h_addr = 3'd2; h_rd = 1'b1;
      @(negedge clk);
      h_rd = 1'b0;
   endtask

   // monitor side of the scoreboard
   always @(posedge clk) pop_seen <= h_rd && (h_addr == 3'd2);

   always @(negedge clk) begin
      if (pop_seen) begin
         if (exp_q.size() == 0) check({cur_tag, " unexpected pop"}, h_rdata, 8'hxx);
         else check({cur_tag, " result byte"}, h_rdata, exp_q.pop_front());
      end
   end

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired got=running exp=finished");
         finish_run();
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();

      // R1 reset state
      s_read(0, v); check("R1 status", v, 8'h60);
      s_read(1, v); check("R1 int status", v, 8'h00);
      check("R1 sub irq", {7'd0, sub_irq_o}, 8'h00);
      check("R1 host irq", {7'd0, host_irq_o}, 8'h00);

      // R2 ordering
      cur_tag = "R2";
      drv_push(8'h11); drv_push(8'h22); drv_push(8'h33);
      s_read(0, v); check("R2 status partly filled", v, 8'h40);
      h_pop(); h_pop(); h_pop();
      idle();
      // R5 empty status and event
      s_read(0, v); check("R5 status empty", v, 8'h60);
      s_read(1, v); check("R5 empty event", v, 8'h20);
      s_write(1, 8'hFF); idle();
      s_read(1, v); check("R9 cleared", v, 8'h00);

      // R3 full and dropped write
      cur_tag = "R3";
      for (int i = 0; i < 9; i++) drv_push(8'hA0 + 8'(i));
      s_read(0, v); check("R3 status full", v, 8'h00);
      for (int i = 0; i < 8; i++) h_pop();
      idle();
      s_read(0, v); check("R3 status drained", v, 8'h60);

      // R4 empty read repeats last byte
      cur_tag = "R4";
      h_pop(); h_pop();
      idle();
      s_read(0, v); check("R4 still empty", v, 8'h60);
      drv_push(8'h55); h_pop(); idle();

      // R6 busy handshake
      h_write(0, 8'h15);
      s_read(0, v); check("R6 busy set", v, 8'hE0);
      s_read(6, v); check("R6 command byte", v, 8'h15);
      s_read(1, v); check("R6 command event", v & 8'h02, 8'h02);
      s_write(3, 8'h01); idle();
      s_read(0, v); check("R6 busy survives result clear", v, 8'hE0);
      s_write(3, 8'h02); idle();
      s_read(0, v); check("R6 busy cleared", v, 8'h60);

      // R8 self-clearing clear control, clear result
      cur_tag = "R8";
      s_read(3, v); check("R8 clear reg reads zero", v, 8'h00);
      drv_push(8'h71); drv_push(8'h72);
      s_write(3, 8'h01); model_q.delete(); idle();
      s_read(0, v); check("R8 fifo emptied", v, 8'h60);
      h_pop(); idle();

      // R7 parameter handshake
      h_write(1, 8'h3C);
      s_read(0, v); check("R7 param ready", v, 8'h70);
      s_read(2, v); check("R7 param byte", v, 8'h3C);
      s_read(0, v); check("R7 param consumed", v, 8'h60);

      // R9 / R10 interrupt status and mask
      s_write(1, 8'hFF); idle();
      s_write(5, 8'h04);
      evt_i = 8'h08; idle(); evt_i = 8'h00;
      s_read(1, v); check("R9 event latched", v, 8'h08);
      check("R10 masked off", {7'd0, sub_irq_o}, 8'h00);
      evt_i = 8'h04; idle(); evt_i = 8'h00;
      s_read(1, v); check("R10 mask leaves status", v, 8'h0C);
      check("R10 irq raised", {7'd0, sub_irq_o}, 8'h01);
      s_write(1, 8'h04); idle();
      s_read(1, v); check("R9 single bit cleared", v, 8'h08);
      check("R10 irq dropped", {7'd0, sub_irq_o}, 8'h00);
      h_write(3, 8'h80);
      s_read(1, v); check("R9 host reset event", v, 8'h09);

      // R11 host interrupt flags
      s_write(4, 8'h05);
      check("R11 host irq", {7'd0, host_irq_o}, 8'h01);
      h_read(0, v); check("R11 host status", v, 8'h65);
      s_write(4, 8'h00);
      s_read(4, v); check("R11 zero write keeps", v, 8'h05);
      h_write(3, 8'h01);
      s_read(4, v); check("R11 host clear one bit", v, 8'h04);
      h_write(3, 8'h04);
      check("R11 host irq low", {7'd0, host_irq_o}, 8'h00);

      // R12 set and clear in the same cycle
      s_write(1, 8'h08);
      evt_i = 8'h08; idle(); evt_i = 8'h00;
      s_read(1, v); check("R12 status set wins", v, 8'h09);
      s_write(3, 8'h02);
      h_write(0, 8'h21);
      s_read(0, v); check("R12 busy set wins", v, 8'hE0);
      s_write(3, 8'h02); idle();
      s_read(0, v); check("R12 busy later cleared", v, 8'h60);

      // R13 DMA busy follows input
      dma_busy_i = 1'b1; idle();
      s_read(0, v); check("R13 dma high", v, 8'h68);
      dma_busy_i = 1'b0; idle();
      s_read(0, v); check("R13 dma low", v, 8'h60);

      idle(); idle();
      check("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
      done = 1'b1;
      finish_run();
   end
endmodule